// File: doc/BRIEF.md
# Interrupt-Driven Doze Clock Gater

This block decides whether the low-speed CPU clock may run while the chip is in its doze power state. In doze the clock is normally stopped. When the periodic wake option is on, it is restarted by the system timer interrupt line, and it stays on while that interrupt's in-service flag is set. Stopping is never immediate. The clock is stopped only on a DRAM refresh strobe, after the wake condition has cleared. An optional hangover keeps the clock alive for a fixed number of refresh strobes after servicing ends.

The block also drives the enables for the three PLLs. The high-speed PLL is always off in doze. The low-speed and video PLLs can be shut down in doze as a configuration choice. Because the timer runs from the low-speed PLL, shutting that PLL down also disables the timer wake. On entry to doze the block can issue a single-cycle NMI or SMI request. While the handler for that request runs, the clock enable is forced on.

Every input is treated as asynchronous and passes through a synchronizer. The refresh strobe is then edge-detected, so each rising edge counts as exactly one strobe.

Top module: `doze_clk_gate`

## Requirements
- R1: In doze (mode code 2'b10) with wake enabled and the PLL shutdown option clear, a high timer interrupt or a high in-service flag turns the clock enable on within three clock cycles and keeps it on.
- R2: Once the wake condition has cleared in doze and no hangover is configured, the clock enable stays on until the first refresh strobe rising edge, and goes low only in response to that edge.
- R3: With the hangover option set, the clock enable stays on through 63 refresh strobes after the wake condition clears, and goes low on the 64th.
- R4: If the interrupt line or the in-service flag reasserts during a hangover, the count restarts, so 64 fresh strobes are again needed to stop the clock.
- R5: In doze with the PLL shutdown option set, the low-speed and video PLL enables are low and the timer wake has no effect on the clock enable. Outside doze those enables are high whatever the option says.
- R6: The high-speed PLL enable is low in doze and high in every other mode code (2'b00, 2'b01, 2'b11).
- R7: While the handler-active input is high in doze, the clock enable is on, even when wake is suppressed.
- R8: Each entry into doze with the request option set produces exactly one single-cycle pulse. The pulse appears on the NMI output when the select bit is 0 and on the SMI output when it is 1. With the request option clear, no pulse appears.
- R9: Leaving doze turns the clock enable on and discards any remaining hangover. After re-entering doze with no wake, one refresh strobe stops the clock.
- R10: With the wake option clear, a high timer interrupt in doze does not start the clock.
- R11: After reset the clock enable and all three PLL enables are high, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pm_mode_i | input | 2 | Power mode code; 2'b10 is doze |
| tmr_irq_i | input | 1 | System timer interrupt line |
| tmr_isr_i | input | 1 | In-service flag of the timer interrupt |
| refresh_i | input | 1 | DRAM refresh strobe; each rising edge is one strobe |
| hdlr_active_i | input | 1 | High while the doze-entry NMI/SMI handler runs |
| cfg_wake_en_i | input | 1 | Enables the periodic timer wake in doze |
| cfg_hang_en_i | input | 1 | Enables the 64-strobe hangover |
| cfg_pll_off_i | input | 1 | Shuts down the low-speed and video PLLs in doze |
| cfg_req_en_i | input | 1 | Enables the doze-entry request |
| cfg_req_smi_i | input | 1 | Request type: 0 = NMI, 1 = SMI |
| cpu_clk_en_o | output | 1 | Low-speed CPU clock enable |
| hs_pll_en_o | output | 1 | High-speed PLL enable |
| ls_pll_en_o | output | 1 | Low-speed PLL enable |
| vid_pll_en_o | output | 1 | Video PLL enable |
| nmi_req_o | output | 1 | Single-cycle NMI request |
| smi_req_o | output | 1 | Single-cycle SMI request |

## Verification
The bench checks that the clock survives the fall of the wake condition until a refresh arrives. A gater that stopped on the falling edge of the condition would show the enable low before any strobe. It counts the hangover to the exact strobe and catches an off-by-one counter, which stops one strobe early or late. It also checks that an interrupt in mid-hangover restarts the count, where a design that merely pauses would stop early. Further cases cover a wake with the PLL shut down, which a faulty design would let through, a stale hangover carried across a doze exit, and a request that repeats or goes to the wrong output.

// File: rtl/doze_pkg.sv
package doze_pkg;

  typedef enum logic [1:0] {
    PM_HIGH = 2'b00,
    PM_LOW  = 2'b01,
    PM_DOZE = 2'b10,
    PM_DEEP = 2'b11
  } pm_mode_e;

  // Bit positions inside the synchronized input vector.
  localparam int unsigned SI_MODE0   = 0;
  localparam int unsigned SI_MODE1   = 1;
  localparam int unsigned SI_IRQ     = 2;
  localparam int unsigned SI_ISR     = 3;
  localparam int unsigned SI_REFRESH = 4;
  localparam int unsigned SI_HDLR    = 5;
  localparam int unsigned SI_WAKE    = 6;
  localparam int unsigned SI_HANG    = 7;
  localparam int unsigned SI_PLLOFF  = 8;
  localparam int unsigned SI_REQEN   = 9;
  localparam int unsigned SI_REQSMI  = 10;
  localparam int unsigned SI_WIDTH   = 11;

  function automatic logic is_doze(input logic [1:0] mode);
    return mode == PM_DOZE;
  endfunction

endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/doze_edge.sv
module doze_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);

  logic level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign rise = level & ~level_d;

endmodule

// File: rtl/doze_run_ctrl.sv
module doze_run_ctrl #(
  parameter int unsigned HANG_STROBES = 64,
  localparam int unsigned CW = $clog2(HANG_STROBES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_doze,
  input  logic          wake_cond,
  input  logic          hdlr_on,
  input  logic          hang_en,
  input  logic          refresh_rise,
  output logic          run,
  output logic [CW-1:0] left
);

  // Strobes still allowed before the clock stops; 1 means "stop at next".
  function automatic logic [CW-1:0] reload_val(input logic hang);
    return hang ? CW'(HANG_STROBES) : CW'(1);
  endfunction

  function automatic logic [CW-1:0] after_strobe(input logic [CW-1:0] cur);
    return (cur > CW'(1)) ? cur - CW'(1) : '0;
  endfunction

  function automatic logic keep_after_strobe(input logic [CW-1:0] cur);
    return cur > CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b1;
      left <= CW'(1);
    end else if (!in_doze) begin
      run  <= 1'b1;
      left <= CW'(1);
    end else if (wake_cond) begin
      run  <= 1'b1;
      left <= reload_val(hang_en);
    end else if (hdlr_on) begin
      run  <= 1'b1;
      if (left == '0) left <= CW'(1);
    end else if (refresh_rise && run) begin
      run  <= keep_after_strobe(left);
      left <= after_strobe(left);
    end
  end

endmodule

// File: rtl/doze_req_gen.sv
module doze_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic in_doze,
  input  logic req_en,
  input  logic req_smi,
  output logic entry,
  output logic nmi_req,
  output logic smi_req
);

  logic doze_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doze_d <= 1'b0;
    else        doze_d <= in_doze;
  end

  assign entry = in_doze & ~doze_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_req <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      nmi_req <= entry & req_en & ~req_smi;
      smi_req <= entry & req_en & req_smi;
    end
  end

endmodule

// File: rtl/doze_clk_gate.sv
module doze_clk_gate
  import doze_pkg::*;
#(
  parameter int unsigned HANG_STROBES = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pm_mode_i,
  input  logic       tmr_irq_i,
  input  logic       tmr_isr_i,
  input  logic       refresh_i,
  input  logic       hdlr_active_i,
  input  logic       cfg_wake_en_i,
  input  logic       cfg_hang_en_i,
  input  logic       cfg_pll_off_i,
  input  logic       cfg_req_en_i,
  input  logic       cfg_req_smi_i,
  output logic       cpu_clk_en_o,
  output logic       hs_pll_en_o,
  output logic       ls_pll_en_o,
  output logic       vid_pll_en_o,
  output logic       nmi_req_o,
  output logic       smi_req_o
);

  localparam int unsigned CW = $clog2(HANG_STROBES + 1);

  logic [SI_WIDTH-1:0] raw_in;
  logic [SI_WIDTH-1:0] syn;

  always_comb begin
    raw_in             = '0;
    raw_in[SI_MODE0]   = pm_mode_i[0];
    raw_in[SI_MODE1]   = pm_mode_i[1];
    raw_in[SI_IRQ]     = tmr_irq_i;
    raw_in[SI_ISR]     = tmr_isr_i;
    raw_in[SI_REFRESH] = refresh_i;
    raw_in[SI_HDLR]    = hdlr_active_i;
    raw_in[SI_WAKE]    = cfg_wake_en_i;
    raw_in[SI_HANG]    = cfg_hang_en_i;
    raw_in[SI_PLLOFF]  = cfg_pll_off_i;
    raw_in[SI_REQEN]   = cfg_req_en_i;
    raw_in[SI_REQSMI]  = cfg_req_smi_i;
  end

  doze_sync #(.WIDTH(SI_WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn)
  );

  // Named internal events, observed by the bound checker.
  logic          in_doze;
  logic          pll_off_s;
  logic          hdlr_s;
  logic          wake_cond;
  logic          refresh_rise;
  logic          doze_entry;
  logic          run;
  logic [CW-1:0] hang_left;

  assign in_doze   = is_doze({syn[SI_MODE1], syn[SI_MODE0]});
  assign pll_off_s = syn[SI_PLLOFF];
  assign hdlr_s    = syn[SI_HDLR];
  assign wake_cond = syn[SI_WAKE] & ~pll_off_s & (syn[SI_IRQ] | syn[SI_ISR]);

  doze_edge u_refresh_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (syn[SI_REFRESH]),
    .rise  (refresh_rise)
  );

  doze_run_ctrl #(.HANG_STROBES(HANG_STROBES)) u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_doze      (in_doze),
    .wake_cond    (wake_cond),
    .hdlr_on      (hdlr_s),
    .hang_en      (syn[SI_HANG]),
    .refresh_rise (refresh_rise),
    .run          (run),
    .left         (hang_left)
  );

  doze_req_gen u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_doze (in_doze),
    .req_en  (syn[SI_REQEN]),
    .req_smi (syn[SI_REQSMI]),
    .entry   (doze_entry),
    .nmi_req (nmi_req_o),
    .smi_req (smi_req_o)
  );

  assign cpu_clk_en_o = run;
  assign hs_pll_en_o  = ~in_doze;
  assign ls_pll_en_o  = ~(in_doze & pll_off_s);
  assign vid_pll_en_o = ~(in_doze & pll_off_s);

endmodule

// File: rtl/doze_clk_gate_chk.sv
module doze_clk_gate_chk #(
  parameter int unsigned HANG_STROBES = 64,
  localparam int unsigned CW = $clog2(HANG_STROBES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_doze,
  input logic          wake_cond,
  input logic          hdlr_s,
  input logic          refresh_rise,
  input logic [CW-1:0] hang_left,
  input logic          cpu_clk_en_o,
  input logic          nmi_req_o,
  input logic          smi_req_o
);

  // R1: a wake in doze makes the clock run on the next cycle
  a_r1_wake_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_doze && wake_cond) |=> cpu_clk_en_o);

  // R2: the clock only stops in response to a refresh edge
  a_r2_stop_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en_o) |-> $past(refresh_rise));

  // R2: with no refresh edge a running clock keeps running
  a_r2_hold_without_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && !refresh_rise) |=> cpu_clk_en_o);

  // R3: the hangover count never exceeds its reload value
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hang_left <= CW'(HANG_STROBES));

  // R7: an active handler keeps the clock on
  a_r7_handler_runs: assert property (@(posedge clk) disable iff (!rst_n)
    hdlr_s |=> cpu_clk_en_o);

  // R8: requests are single-cycle and never both at once
  a_r8_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |=> !nmi_req_o);
  a_r8_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req_o |=> !smi_req_o);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req_o && smi_req_o));

  // R9: outside doze the clock is on
  a_r9_exit_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !in_doze |=> cpu_clk_en_o);

endmodule

bind doze_clk_gate doze_clk_gate_chk #(.HANG_STROBES(HANG_STROBES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_doze      (in_doze),
  .wake_cond    (wake_cond),
  .hdlr_s       (hdlr_s),
  .refresh_rise (refresh_rise),
  .hang_left    (hang_left),
  .cpu_clk_en_o (cpu_clk_en_o),
  .nmi_req_o    (nmi_req_o),
  .smi_req_o    (smi_req_o)
);

// File: tb/doze_clk_gate_bench.sv
module doze_clk_gate_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HANG       = 64;
  localparam int unsigned SETTLE     = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pm_mode_i = 2'b01;
  logic       tmr_irq_i = 1'b0;
  logic       tmr_isr_i = 1'b0;
  logic       refresh_i = 1'b0;
  logic       hdlr_active_i = 1'b0;
  logic       cfg_wake_en_i = 1'b0;
  logic       cfg_hang_en_i = 1'b0;
  logic       cfg_pll_off_i = 1'b0;
  logic       cfg_req_en_i = 1'b0;
  logic       cfg_req_smi_i = 1'b0;
  logic       cpu_clk_en_o, hs_pll_en_o, ls_pll_en_o, vid_pll_en_o;
  logic       nmi_req_o, smi_req_o;

  int checks = 0;
  int errors = 0;
  int nmi_cnt = 0;
  int smi_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doze_clk_gate u_doze_clk_gate (
    .clk (clk), .rst_n (rst_n), .pm_mode_i (pm_mode_i),
    .tmr_irq_i (tmr_irq_i), .tmr_isr_i (tmr_isr_i), .refresh_i (refresh_i),
    .hdlr_active_i (hdlr_active_i), .cfg_wake_en_i (cfg_wake_en_i),
    .cfg_hang_en_i (cfg_hang_en_i), .cfg_pll_off_i (cfg_pll_off_i),
    .cfg_req_en_i (cfg_req_en_i), .cfg_req_smi_i (cfg_req_smi_i),
    .cpu_clk_en_o (cpu_clk_en_o), .hs_pll_en_o (hs_pll_en_o),
    .ls_pll_en_o (ls_pll_en_o), .vid_pll_en_o (vid_pll_en_o),
    .nmi_req_o (nmi_req_o), .smi_req_o (smi_req_o)
  );

  always @(negedge clk) begin
    if (nmi_req_o) nmi_cnt++;
    if (smi_req_o) smi_cnt++;
  end

  // Row: [11:10] mode [9] irq [8] isr [7] wake [6] hang [5] plloff
  //      [4] hdlr [3] refresh pulse | expected [2] clk_en [1] hs [0] ls/vid
  localparam int NROW = 13;
  localparam logic [11:0] ROWS [NROW] = '{
    12'b01_0_0_0_0_0_0_0_111, // low speed, all running
    12'b10_0_0_1_0_0_0_0_101, // doze, no strobe yet: still on (R2, R6)
    12'b10_0_0_1_0_0_0_1_001, // strobe stops it (R2)
    12'b10_1_0_1_0_0_0_0_101, // irq wakes (R1)
    12'b10_0_1_1_0_0_0_1_101, // isr holds across strobe (R1)
    12'b10_0_0_1_0_0_0_0_101, // condition gone, no strobe (R2)
    12'b10_0_0_1_0_0_0_1_001, // strobe stops (R2)
    12'b10_1_0_1_0_1_0_0_000, // pll off suppresses wake (R5)
    12'b10_1_0_1_0_1_1_0_100, // handler forces on (R7)
    12'b10_0_0_1_0_0_0_1_001, // handler ends, strobe stops (R7, R2)
    12'b10_1_0_0_0_0_0_0_001, // wake disabled (R10)
    12'b00_0_0_0_0_0_0_0_111, // high speed (R6, R9)
    12'b11_0_0_0_0_1_0_0_111  // deep code is not doze (R6, R5)
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic strobe();
    refresh_i = 1'b1;
    @(negedge clk);
    refresh_i = 1'b0;
    wait_cyc(SETTLE);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, s0;
    wait_cyc(3);
    // R11: reset state
    check(cpu_clk_en_o, 1'b1, "R11 clk_en in reset");
    check(hs_pll_en_o,  1'b1, "R11 hs pll in reset");
    check(ls_pll_en_o,  1'b1, "R11 ls pll in reset");
    check(nmi_req_o | smi_req_o, 1'b0, "R11 requests in reset");
    rst_n = 1'b1;
    wait_cyc(SETTLE);

    for (int r = 0; r < NROW; r++) begin
      logic [11:0] v;
      v = ROWS[r];
      pm_mode_i     = v[11:10];
      tmr_irq_i     = v[9];
      tmr_isr_i     = v[8];
      cfg_wake_en_i = v[7];
      cfg_hang_en_i = v[6];
      cfg_pll_off_i = v[5];
      hdlr_active_i = v[4];
      wait_cyc(SETTLE);
      if (v[3]) strobe();
      check(cpu_clk_en_o, v[2], $sformatf("R1/R2/R5/R7/R10 row %0d clk_en", r));
      check(hs_pll_en_o,  v[1], $sformatf("R6 row %0d hs pll", r));
      check(ls_pll_en_o,  v[0], $sformatf("R5 row %0d ls pll", r));
      check(vid_pll_en_o, v[0], $sformatf("R5 row %0d vid pll", r));
    end

    // R3: hangover of 64 strobes
    pm_mode_i = 2'b10; cfg_wake_en_i = 1'b1; cfg_hang_en_i = 1'b1;
    cfg_pll_off_i = 1'b0; tmr_irq_i = 1'b0; hdlr_active_i = 1'b0;
    tmr_isr_i = 1'b1; wait_cyc(SETTLE);
    tmr_isr_i = 1'b0; wait_cyc(SETTLE);
    strobes(HANG - 1);
    check(cpu_clk_en_o, 1'b1, "R3 on after 63 strobes");
    strobe();
    check(cpu_clk_en_o, 1'b0, "R3 off at 64th strobe");

    // R4: reload during hangover
    tmr_isr_i = 1'b1; wait_cyc(SETTLE);
    tmr_isr_i = 1'b0; wait_cyc(SETTLE);
    strobes(30);
    tmr_irq_i = 1'b1; wait_cyc(SETTLE);
    tmr_irq_i = 1'b0; wait_cyc(SETTLE);
    strobes(HANG - 1);
    check(cpu_clk_en_o, 1'b1, "R4 reloaded, on after 63 more");
    strobe();
    check(cpu_clk_en_o, 1'b0, "R4 off at 64th after reload");

    // R9: exit during hangover discards it
    tmr_isr_i = 1'b1; wait_cyc(SETTLE);
    tmr_isr_i = 1'b0; wait_cyc(SETTLE);
    strobes(10);
    pm_mode_i = 2'b01; wait_cyc(SETTLE);
    check(cpu_clk_en_o, 1'b1, "R9 on after leaving doze");
    pm_mode_i = 2'b10; wait_cyc(SETTLE);
    check(cpu_clk_en_o, 1'b1, "R9 on before first strobe");
    strobe();
    check(cpu_clk_en_o, 1'b0, "R9 one strobe stops after re-entry");

    // R8: entry requests
    pm_mode_i = 2'b01; cfg_req_en_i = 1'b1; cfg_req_smi_i = 1'b0;
    wait_cyc(SETTLE);
    n0 = nmi_cnt; s0 = smi_cnt;
    pm_mode_i = 2'b10; wait_cyc(SETTLE + 5);
    check(nmi_cnt - n0 == 1, 1'b1, $sformatf("R8 one NMI pulse (got %0d)", nmi_cnt - n0));
    check(smi_cnt - s0 == 0, 1'b1, "R8 no SMI when NMI selected");
    pm_mode_i = 2'b01; cfg_req_smi_i = 1'b1; wait_cyc(SETTLE);
    n0 = nmi_cnt; s0 = smi_cnt;
    pm_mode_i = 2'b10; wait_cyc(SETTLE + 5);
    check(smi_cnt - s0 == 1, 1'b1, $sformatf("R8 one SMI pulse (got %0d)", smi_cnt - s0));
    check(nmi_cnt - n0 == 0, 1'b1, "R8 no NMI when SMI selected");
    pm_mode_i = 2'b01; cfg_req_en_i = 1'b0; wait_cyc(SETTLE);
    n0 = nmi_cnt; s0 = smi_cnt;
    pm_mode_i = 2'b10; wait_cyc(SETTLE + 5);
    check((nmi_cnt - n0) + (smi_cnt - s0) == 0, 1'b1, "R8 no request when disabled");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule